// File: doc/BRIEF.md
# Forbidden-Latency Initiation Gate

This block decides, one clock at a time, whether a new data set may be started into a non-linear pipeline. Such a pipeline may reuse stages through feedback, or hold one stage for several periods. Software or a setup sequencer writes a usage grid of stages by time slots, one row per write, and then issues a commit. The block then scans the grid one row per clock. For each row it takes every pair of marked slots and records their distance as a forbidden latency. The result is the initial forbidden-latency vector.

At run time the block keeps a state vector whose bit 0 stands for "starting now would collide". The state shifts right by one position every clock. A request is taken only when bit 0 is clear. A taken request merges the initial vector into the shifted state. A request held high is therefore taken at the earliest legal cycle, which is the greedy policy. Every taken start raises a one-clock accept pulse and reports the number of clocks since the previous taken start.

Top module: `coll_init_ctrl`

## Requirements
- R1: A write with `cfg_we_i` high stores `cfg_data_i` as the mark row selected by `cfg_row_i` (bit s marks time slot s). A write presented while `busy_o` is high changes nothing.
- R2: After a derivation, `icv_o` bit b (latency b+1) is 1 exactly when some stored row has marks in two slots that are b+1 apart.
- R3: A commit presented while `busy_o` is low raises `busy_o` on the next clock. `busy_o` stays high for exactly STAGES clocks, and `icv_o` takes its new value on the clock where `busy_o` falls. A commit while busy is ignored.
- R4: Reset and every accepted commit clear the state vector `cv_o` to zero, so the first request after either is accepted.
- R5: While no start is taken, each clock moves `cv_o` right by one position (bit b takes old bit b+1, and the top bit becomes 0).
- R6: A request that arrives while `busy_o` is low, with no commit in the same cycle and with `cv_o[0]` = 1, is rejected: `rej_o` pulses on the next clock and the state only shifts.
- R7: A request that arrives while `busy_o` is low, with no commit in the same cycle and with `cv_o[0]` = 0, is accepted: `acc_o` pulses on the next clock, and `cv_o` becomes the shifted state ORed with `icv_o`.
- R8: A request held high continuously is accepted in every cycle where R7 permits, with no extra wait (greedy).
- R9: With each accept, `lat_o` shows the number of clocks since the previous accept. The count saturates at 2^LAT_W-1, and it reads 0 when there has been no earlier accept since reset.
- R10: With no requests, `cv_o` reaches zero within CV_W clocks of the last accept.
- R11: While `busy_o` is high, or in the cycle of a commit, a request produces neither `acc_o` nor `rej_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we_i | input | 1 | Write one grid row |
| cfg_row_i | input | ROW_W | Row (stage) index for the write |
| cfg_data_i | input | SLOTS | Mark bits of the row, bit s = slot s |
| cfg_commit_i | input | 1 | Start deriving the initial vector |
| req_i | input | 1 | Start request (level) |
| acc_o | output | 1 | Request accepted on the previous clock |
| rej_o | output | 1 | Request rejected on the previous clock |
| busy_o | output | 1 | Derivation in progress |
| cv_o | output | CV_W | Current state vector, bit b = latency b+1 forbidden |
| icv_o | output | CV_W | Initial forbidden-latency vector |
| lat_o | output | LAT_W | Clocks between the last two accepts (saturating) |

## Verification
The hardest case to reach is a state that holds several overlapping merges of the initial vector. Only chains of starts spaced closer than the vector width build it up, and it decides every later reject. The stimulus holds the request high for long stretches so that greedy chains form. It mixes those stretches with runs at different request densities over several random grids. It also drives grid writes and commits while a derivation is running, to show that they leave the grid and the derivation untouched.

// File: rtl/cic_pkg.sv
package cic_pkg;

   typedef enum logic {
      BLD_IDLE = 1'b0,
      BLD_SCAN = 1'b1
   } bld_state_e;

   // next value of a saturating counter held in the low "w" bits
   function automatic logic [31:0] sat_inc(input logic [31:0] v, input int w);
      logic [31:0] top;
      top = (32'd1 << w) - 32'd1;
      return (v >= top) ? top : v + 32'd1;
   endfunction

endpackage

// File: rtl/cic_table_store.sv
module cic_table_store #(
   parameter int STAGES = 4,
   parameter int SLOTS  = 8,
   localparam int ROW_W = (STAGES > 1) ? $clog2(STAGES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [ROW_W-1:0] wr_row,
   input  logic [SLOTS-1:0] wr_data,
   input  logic [ROW_W-1:0] rd_row,
   output logic [SLOTS-1:0] rd_data
);

   logic [SLOTS-1:0] rows_q [STAGES];

   for (genvar r = 0; r < STAGES; r++) begin : g_row
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rows_q[r] <= '0;
         end else if (wr_en && (wr_row == ROW_W'(r))) begin
            rows_q[r] <= wr_data;
         end
      end
   end

   always_comb begin
      rd_data = '0;
      for (int r = 0; r < STAGES; r++) begin
         if (rd_row == ROW_W'(r)) rd_data = rows_q[r];
      end
   end

endmodule

// File: rtl/cic_icv_builder.sv
module cic_icv_builder
   import cic_pkg::*;
#(
   parameter int STAGES = 4,
   parameter int SLOTS  = 8,
   localparam int ROW_W = (STAGES > 1) ? $clog2(STAGES) : 1,
   localparam int CV_W  = SLOTS - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   output logic [ROW_W-1:0] rd_row,
   input  logic [SLOTS-1:0] rd_data,
   output logic             busy,
   output logic [CV_W-1:0]  icv
);

   localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(STAGES - 1);

   bld_state_e      state_q;
   logic [ROW_W-1:0] idx_q;
   logic [CV_W-1:0] acc_q;
   logic [CV_W-1:0] icv_q;
   logic [CV_W-1:0] row_dist;

   // one distance detector per latency: any two marks b+1 slots apart
   for (genvar b = 0; b < CV_W; b++) begin : g_dist
      localparam int SPAN = SLOTS - 1 - b;
      logic [SPAN-1:0] hits;
      for (genvar i = 0; i < SPAN; i++) begin : g_pair
         assign hits[i] = rd_data[i] & rd_data[i+b+1];
      end
      assign row_dist[b] = |hits;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= BLD_IDLE;
         idx_q   <= '0;
         acc_q   <= '0;
         icv_q   <= '0;
      end else begin
         unique case (state_q)
            BLD_IDLE: begin
               if (start) begin
                  state_q <= BLD_SCAN;
                  idx_q   <= '0;
                  acc_q   <= '0;
               end
            end
            BLD_SCAN: begin
               if (idx_q == LAST_ROW) begin
                  state_q <= BLD_IDLE;
                  icv_q   <= acc_q | row_dist;
                  idx_q   <= '0;
               end else begin
                  acc_q <= acc_q | row_dist;
                  idx_q <= idx_q + ROW_W'(1);
               end
            end
            default: state_q <= BLD_IDLE;
         endcase
      end
   end

   assign rd_row = idx_q;
   assign busy   = (state_q == BLD_SCAN);
   assign icv    = icv_q;

endmodule

// File: rtl/cic_cv_state.sv
module cic_cv_state #(
   parameter int CV_W = 7
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clear,
   input  logic            req,
   input  logic            block,
   input  logic [CV_W-1:0] icv,
   output logic            take,
   output logic            acc_q,
   output logic            rej_q,
   output logic [CV_W-1:0] cv
);

   logic [CV_W-1:0] st_q;
   logic [CV_W-1:0] shifted;
   logic            refuse;

   assign shifted = st_q >> 1;
   assign take    = req & ~block & ~st_q[0];
   assign refuse  = req & ~block &  st_q[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= '0;
         acc_q <= 1'b0;
         rej_q <= 1'b0;
      end else begin
         acc_q <= take;
         rej_q <= refuse;
         if (clear)     st_q <= '0;
         else if (take) st_q <= shifted | icv;
         else           st_q <= shifted;
      end
   end

   assign cv = st_q;

endmodule

// File: rtl/cic_lat_counter.sv
module cic_lat_counter
   import cic_pkg::*;
#(
   parameter int LAT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   output logic [LAT_W-1:0] lat
);

   // cnt_q == 0 means no accept seen yet; otherwise clocks since it
   logic [LAT_W-1:0] cnt_q;
   logic [LAT_W-1:0] lat_q;
   logic [LAT_W-1:0] cnt_next;

   assign cnt_next = LAT_W'(sat_inc(32'(cnt_q), LAT_W));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         lat_q <= '0;
      end else if (take) begin
         lat_q <= cnt_q;
         cnt_q <= LAT_W'(1);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_next;
      end
   end

   assign lat = lat_q;

endmodule

// File: rtl/coll_init_ctrl.sv
module coll_init_ctrl #(
   parameter int STAGES = 4,
   parameter int SLOTS  = 8,
   parameter int LAT_W  = 4,
   localparam int ROW_W = (STAGES > 1) ? $clog2(STAGES) : 1,
   localparam int CV_W  = SLOTS - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we_i,
   input  logic [ROW_W-1:0] cfg_row_i,
   input  logic [SLOTS-1:0] cfg_data_i,
   input  logic             cfg_commit_i,
   input  logic             req_i,
   output logic             acc_o,
   output logic             rej_o,
   output logic             busy_o,
   output logic [CV_W-1:0]  cv_o,
   output logic [CV_W-1:0]  icv_o,
   output logic [LAT_W-1:0] lat_o
);

   if (STAGES < 1 || STAGES > 8) begin : g_bad_stages
      $error("coll_init_ctrl: STAGES must be 1..8");
   end
   if (SLOTS < 2 || SLOTS > 16) begin : g_bad_slots
      $error("coll_init_ctrl: SLOTS must be 2..16");
   end
   if (LAT_W < 1 || LAT_W > 16) begin : g_bad_lat
      $error("coll_init_ctrl: LAT_W must be 1..16");
   end

   logic             busy;
   logic             wr_ok;
   logic             start_ok;
   logic [ROW_W-1:0] rd_row;
   logic [SLOTS-1:0] rd_data;
   logic [CV_W-1:0]  icv;
   logic             take;

   assign wr_ok    = cfg_we_i & ~busy;
   assign start_ok = cfg_commit_i & ~busy;

   cic_table_store #(.STAGES(STAGES), .SLOTS(SLOTS)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_ok),
      .wr_row  (cfg_row_i),
      .wr_data (cfg_data_i),
      .rd_row  (rd_row),
      .rd_data (rd_data)
   );

   cic_icv_builder #(.STAGES(STAGES), .SLOTS(SLOTS)) u_build (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start_ok),
      .rd_row  (rd_row),
      .rd_data (rd_data),
      .busy    (busy),
      .icv     (icv)
   );

   cic_cv_state #(.CV_W(CV_W)) u_state (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (start_ok),
      .req   (req_i),
      .block (busy | cfg_commit_i),
      .icv   (icv),
      .take  (take),
      .acc_q (acc_o),
      .rej_q (rej_o),
      .cv    (cv_o)
   );

   cic_lat_counter #(.LAT_W(LAT_W)) u_lat (
      .clk   (clk),
      .rst_n (rst_n),
      .take  (take),
      .lat   (lat_o)
   );

   assign busy_o = busy;
   assign icv_o  = icv;

endmodule

// File: rtl/cic_checker.sv
module cic_checker #(
   parameter int CV_W = 7
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cfg_commit_i,
   input logic            req_i,
   input logic            acc_o,
   input logic            rej_o,
   input logic            busy_o,
   input logic [CV_W-1:0] cv_o,
   input logic [CV_W-1:0] icv_o
);

   AST_ACC_REJ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_o && rej_o)); // R6

   AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o || cfg_commit_i) |=> (!acc_o && !rej_o)); // R11

   AST_FORBIDDEN_REJ: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !cfg_commit_i && req_i && cv_o[0]) |=> rej_o); // R6

   AST_FREE_ACC: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !cfg_commit_i && req_i && !cv_o[0]) |=> acc_o); // R8

   AST_MERGE_ICV: assert property (@(posedge clk) disable iff (!rst_n)
      acc_o |-> ((cv_o & icv_o) == icv_o)); // R7

   AST_IDLE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_i && !cfg_commit_i) |=> (cv_o == ($past(cv_o) >> 1))); // R5

   AST_ICV_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !cfg_commit_i) |=> $stable(icv_o)); // R3

endmodule

bind coll_init_ctrl cic_checker #(.CV_W(CV_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_commit_i (cfg_commit_i),
   .req_i        (req_i),
   .acc_o        (acc_o),
   .rej_o        (rej_o),
   .busy_o       (busy_o),
   .cv_o         (cv_o),
   .icv_o        (icv_o)
);

// File: tb/coll_init_ctrl_tb_top.sv
module coll_init_ctrl_tb_top;

   localparam int STAGES = 4;
   localparam int SLOTS  = 8;
   localparam int LAT_W  = 4;
   localparam int ROW_W  = 2;
   localparam int CV_W   = SLOTS - 1;
   localparam int LMAX   = (1 << LAT_W) - 1;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cfg_we_i = 1'b0;
   logic [ROW_W-1:0] cfg_row_i = '0;
   logic [SLOTS-1:0] cfg_data_i = '0;
   logic             cfg_commit_i = 1'b0;
   logic             req_i = 1'b0;
   logic             acc_o, rej_o, busy_o;
   logic [CV_W-1:0]  cv_o, icv_o;
   logic [LAT_W-1:0] lat_o;

   always #2.5 clk = ~clk;

   coll_init_ctrl #(.STAGES(STAGES), .SLOTS(SLOTS), .LAT_W(LAT_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we_i), .cfg_row_i(cfg_row_i),
      .cfg_data_i(cfg_data_i), .cfg_commit_i(cfg_commit_i), .req_i(req_i),
      .acc_o(acc_o), .rej_o(rej_o), .busy_o(busy_o), .cv_o(cv_o),
      .icv_o(icv_o), .lat_o(lat_o)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // reference model state
   logic [SLOTS-1:0] m_tab [STAGES];
   logic [CV_W-1:0]  m_icv = '0, m_st = '0;
   int               m_cnt = 0, m_bcnt = 0;
   bit               m_busy = 0;
   bit               e_acc = 0, e_rej = 0;
   int               e_lat = 0;

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   function automatic logic [CV_W-1:0] calc_icv();
      logic [CV_W-1:0] v = '0;
      for (int r = 0; r < STAGES; r++)
         for (int b = 0; b < CV_W; b++)
            for (int i = 0; i + b + 1 < SLOTS; i++)
               if (m_tab[r][i] && m_tab[r][i+b+1]) v[b] = 1'b1;
      return v;
   endfunction

   // drive one cycle (called at a falling edge), update model, compare at next falling edge
   task automatic step(input bit r, input bit we, input int row, input int d, input bit cm);
      bit blocked, a, j;
      req_i = r; cfg_we_i = we; cfg_row_i = ROW_W'(row);
      cfg_data_i = SLOTS'(d); cfg_commit_i = cm;
      blocked = m_busy || cm;
      a = r && !blocked && !m_st[0];
      j = r && !blocked && m_st[0];
      e_acc = a; e_rej = j;
      if (a) e_lat = m_cnt;
      if (a) m_cnt = 1;
      else if (m_cnt != 0 && m_cnt < LMAX) m_cnt++;
      if (cm && !m_busy) m_st = '0;
      else if (a) m_st = (m_st >> 1) | m_icv;
      else m_st = m_st >> 1;
      if (we && !m_busy) m_tab[row] = SLOTS'(d);
      if (m_busy) begin
         m_bcnt--;
         if (m_bcnt == 0) begin
            m_busy = 0;
            m_icv = calc_icv();
         end
      end else if (cm) begin
         m_busy = 1;
         m_bcnt = STAGES;
      end
      @(negedge clk);
      chk(acc_o === e_acc, "R7 acc_o", int'(acc_o), int'(e_acc));
      chk(rej_o === e_rej, "R6 rej_o", int'(rej_o), int'(e_rej));
      chk(busy_o === m_busy, "R3 busy_o", int'(busy_o), int'(m_busy));
      chk(cv_o === m_st, "R5 cv_o", int'(cv_o), int'(m_st));
      chk(icv_o === m_icv, "R2 icv_o", int'(icv_o), int'(m_icv));
      chk(int'(lat_o) == e_lat, "R9 lat_o", int'(lat_o), e_lat);
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0);
   endtask

   task automatic load_commit(input int r0, input int r1, input int r2, input int r3);
      step(0, 1, 0, r0, 0);
      step(0, 1, 1, r1, 0);
      step(0, 1, 2, r2, 0);
      step(0, 1, 3, r3, 0);
      step(0, 0, 0, 0, 1);
      idle(STAGES);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: run did not end actual=0 expected=1");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : main
      int acc_seen;
      int lats [4];
      void'($urandom(32'h5EED_0C1C));
      for (int r = 0; r < STAGES; r++) m_tab[r] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R4 reset state
      chk(cv_o == '0 && !busy_o && !acc_o && !rej_o && lat_o == '0,
          "R4 reset state", int'(cv_o), 0);

      // directed grid: slots {0,7}, {1,2}, {3,5} -> latencies 7,1,2 forbidden
      load_commit(8'h81, 8'h06, 8'h28, 8'h00);
      chk(icv_o == 7'h43, "R2 directed icv", int'(icv_o), 'h43);

      // R8 greedy: held request, record latencies of first accepts
      acc_seen = 0;
      for (int k = 0; k < 20; k++) begin
         step(1, 0, 0, 0, 0);
         if (acc_o && acc_seen < 4) begin
            lats[acc_seen] = int'(lat_o);
            acc_seen++;
         end
      end
      chk(acc_seen == 4, "R8 greedy accepts", acc_seen, 4);
      chk(lats[0] == 0, "R9 first latency", lats[0], 0);
      chk(lats[1] == 3, "R8 greedy latency", lats[1], 3);
      chk(lats[2] == 3, "R8 greedy cycle", lats[2], 3);

      // R10 idle clears state
      idle(CV_W);
      chk(cv_o == '0, "R10 idle clear", int'(cv_o), 0);

      // R9 saturation after a long gap
      idle(20);
      step(1, 0, 0, 0, 0);
      chk(acc_o && int'(lat_o) == LMAX, "R9 saturate", int'(lat_o), LMAX);
      step(0, 0, 0, 0, 0);

      // R1 / R11: write and request while busy are ignored; R4 first request accepted
      step(1, 0, 0, 0, 0);
      step(0, 0, 0, 0, 1);
      step(1, 1, 3, 8'hFF, 1);
      step(1, 1, 3, 8'hFF, 0);
      chk(!acc_o && !rej_o, "R11 busy request", int'(acc_o), 0);
      idle(STAGES - 2);
      chk(icv_o == 7'h43, "R1 busy write ignored", int'(icv_o), 'h43);
      step(1, 0, 0, 0, 0);
      chk(acc_o === 1'b1, "R4 first after commit", int'(acc_o), 1);

      // random grids and request densities
      for (int g = 0; g < 8; g++) begin
         int pct;
         pct = (g % 4 == 3) ? 100 : 15 + 25 * (g % 4);
         load_commit(int'($urandom & $urandom & 8'hFF), int'($urandom & $urandom & 8'hFF),
                     int'($urandom & $urandom & 8'hFF), int'($urandom & $urandom & 8'hFF));
         for (int k = 0; k < 180; k++) begin
            bit r, we, cm;
            r  = ($urandom % 100) < pct;
            we = ($urandom % 100) < 4;
            cm = ($urandom % 200) == 0;
            step(r, we, int'($urandom % STAGES), int'($urandom % 256), cm);
         end
         idle(STAGES + 1);
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule